// File: doc/BRIEF.md
# Outstanding Prefetch Request Queue

This block sits between a processor and its local cache controller and tracks prefetch requests that are waiting on the ring. Each request names one 128-byte coherence unit by its unit address and asks for either a shared-read copy or exclusive ownership. The processor does not wait for a prefetch to complete. The block looks up the unit's current local-cache state in the same cycle as the request. If the cache already holds the unit in the requested state or a stronger one, the request is discarded and nothing goes out on the ring.

Requests that survive the lookup either merge into an outstanding entry for the same unit or take a free slot. The queue holds at most DEPTH entries, 4 by default. New entries are sent to the ring in the order they arrived, over a valid/ready handshake. Entries retire in any order, when a ring response with a matching unit address comes back.

When every slot is taken, a request flagged as non-blocking is dropped without notice. A request flagged as blocking is parked instead. The processor is stalled on its next local-cache access and stays stalled until a slot frees, and the parked request then enters the queue.

Top module: `pf_outstanding_queue`

## Requirements
- R1: A request is discarded with no ring request when the looked-up cache state covers it. State codes are 0 invalid, 1 shared and 2 exclusive. A shared request is covered by state 1 or 2, and an exclusive request only by state 2.
- R2: An accepted request appears on the ring port in the cycle after acceptance, with its unit address and `ring_excl` = 1 for exclusive. The address is held unchanged while `ring_ready` is low.
- R3: Entries go to the ring in arrival order, at most one per cycle, popping each cycle that `ring_ready` is high.
- R4: A request whose address matches an outstanding entry creates no new entry and no second ring request. An exclusive request that matches a shared entry not yet issued upgrades that entry to exclusive.
- R5: An exclusive request that matches a shared entry already issued to the ring is discarded.
- R6: A response whose address matches an issued entry frees that entry, whatever its position in the queue. The freed slot can be reused by the next request.
- R7: A response that matches no issued entry changes no entry and sets `rsp_err`. The flag stays set until reset.
- R8: A non-blocking request that arrives while all DEPTH slots are occupied, with none retiring in that cycle, is dropped and never reaches the ring.
- R9: A blocking request that arrives while the queue is full is parked. `stall` rises on the first cycle with `cpu_access` high and stays high until a slot frees. The parked request is then issued. Requests presented while a request is parked are ignored.
- R10: `stall` is low whenever no blocking request is parked or a slot is free.
- R11: After reset `ring_valid`, `stall` and `rsp_err` are low.
- R12: At most DEPTH distinct units are outstanding at once. DEPTH distinct requests into an empty queue are all issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Prefetch request present |
| req_addr | input | AW | Unit address of the request |
| req_excl | input | 1 | 1 requests exclusive, 0 shared |
| req_block | input | 1 | 1 means the request must not be dropped |
| lk_addr | output | AW | Address looked up in the local cache |
| lk_state | input | 2 | Local-cache state of lk_addr (0/1/2) |
| cpu_access | input | 1 | Processor performs a local-cache access |
| stall | output | 1 | Stall to the processor |
| ring_valid | output | 1 | Ring request pending |
| ring_ready | input | 1 | Ring accepts the request |
| ring_addr | output | AW | Unit address of the ring request |
| ring_excl | output | 1 | Ring request asks for exclusive |
| rsp_valid | input | 1 | Ring response present |
| rsp_addr | input | AW | Unit address of the response |
| rsp_err | output | 1 | Sticky unmatched-response flag |

## Verification
The checker enforces these invariants on every cycle:
- the issue order never holds more entries than are occupied;
- stall only appears when every slot is taken;
- the ring head is never an entry already issued;
- a covered request leaves the slots untouched;
- the error flag is sticky;
- a waiting ring request holds its address.

Only the bench scenarios can show the rest:
- the exact lookup-filter table;
- the issue order;
- upgrade against discard on a merge;
- out-of-order retirement freeing the right slot;
- the drop of a non-blocking request against the parking of a blocking one, including the cycle the stall begins and ends.

// File: rtl/pfq_pkg.sv
// Package: shared state encoding for the prefetch queue.
// Assumes the local cache reports a 2-bit ownership state.
package pfq_pkg;
    typedef enum logic [1:0] {
        ST_INVALID = 2'd0,
        ST_SHARED  = 2'd1,
        ST_EXCL    = 2'd2
    } cstate_e;
endpackage

// File: rtl/pfq_filter.sv
// Module: decides whether the local cache already satisfies a request.
// Assumes state codes from pfq_pkg; code 3 is treated like exclusive.
module pfq_filter (
    input  logic [1:0] held_state,
    input  logic       want_excl,
    output logic       covered
);
    import pfq_pkg::*;

    // Compare held ownership against the requested strength
    always_comb begin
        if (want_excl) begin
            covered = (held_state >= ST_EXCL);
        end else begin
            covered = (held_state != ST_INVALID);
        end
    end
endmodule

// File: rtl/pfq_slots.sv
// Module: storage for outstanding entries with address match, retire and
// free-slot selection. Assumes at most one allocation per cycle and that
// allocation takes priority over retire on the same slot.
module pfq_slots #(
    parameter int DEPTH = 4,
    parameter int AW    = 25,
    parameter int IW    = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [AW-1:0]             cmp_addr,
    input  logic                      rsp_valid,
    input  logic [AW-1:0]             rsp_addr,
    input  logic                      alloc_en,
    input  logic [AW-1:0]             alloc_addr,
    input  logic                      alloc_excl,
    input  logic                      upg_en,
    input  logic [IW-1:0]             upg_idx,
    input  logic                      mark_en,
    input  logic [IW-1:0]             mark_idx,
    output logic [DEPTH-1:0]          slot_valid,
    output logic [DEPTH-1:0]          slot_issued,
    output logic [DEPTH-1:0]          slot_excl,
    output logic [DEPTH-1:0][AW-1:0]  slot_addr,
    output logic [DEPTH-1:0]          hit_vec,
    output logic                      rsp_hit,
    output logic                      any_free,
    output logic [IW-1:0]             alloc_idx
);
    logic [DEPTH-1:0] retire_vec;
    logic [DEPTH-1:0] free_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Match logic for one slot: response retire and request lookup
        always_comb begin
            retire_vec[g] = rsp_valid && slot_valid[g] && slot_issued[g]
                            && (slot_addr[g] == rsp_addr);
            hit_vec[g]    = slot_valid[g] && !retire_vec[g]
                            && (slot_addr[g] == cmp_addr);
            free_vec[g]   = !slot_valid[g] || retire_vec[g];
        end

        // State update for one slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_valid[g]  <= 1'b0;
                slot_issued[g] <= 1'b0;
                slot_excl[g]   <= 1'b0;
                slot_addr[g]   <= '0;
            end else if (alloc_en && (alloc_idx == IW'(g))) begin
                slot_valid[g]  <= 1'b1;
                slot_issued[g] <= 1'b0;
                slot_excl[g]   <= alloc_excl;
                slot_addr[g]   <= alloc_addr;
            end else begin
                if (retire_vec[g]) begin
                    slot_valid[g] <= 1'b0;
                end
                if (upg_en && (upg_idx == IW'(g))) begin
                    slot_excl[g] <= 1'b1;
                end
                if (mark_en && (mark_idx == IW'(g))) begin
                    slot_issued[g] <= 1'b1;
                end
            end
        end
    end

    // Lowest free slot and summary flags
    always_comb begin
        alloc_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                alloc_idx = IW'(i);
            end
        end
        any_free = |free_vec;
        rsp_hit  = |retire_vec;
    end
endmodule

// File: rtl/pfq_order.sv
// Module: circular list of slot indices giving ring issue order.
// Assumes the producer never pushes when DEPTH indices are already held.
module pfq_order #(
    parameter int DEPTH = 4,
    parameter int IW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] push_idx,
    input  logic          pop,
    output logic [IW-1:0] head_idx,
    output logic          nonempty,
    output logic [CW-1:0] count
);
    logic [IW-1:0] mem [DEPTH];
    logic [IW-1:0] rd_ptr;
    logic [IW-1:0] wr_ptr;

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Pointer, count and storage update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_idx;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= nxt(rd_ptr);
            end
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // Head view for the ring port
    always_comb begin
        head_idx = mem[rd_ptr];
        nonempty = (count != '0);
    end
endmodule

// File: rtl/pf_outstanding_queue.sv
// Module: outstanding prefetch queue. It filters requests against the
// local-cache state, merges same-unit requests, issues new entries in
// arrival order and retires entries on matching responses. When the queue
// is full it drops or parks a request, chosen per request. Assumes the
// cache lookup answers in the same cycle and that a response never arrives
// in the cycle its request is issued.
module pf_outstanding_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 25
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_excl,
    input  logic          req_block,
    output logic [AW-1:0] lk_addr,
    input  logic [1:0]    lk_state,
    input  logic          cpu_access,
    output logic          stall,
    output logic          ring_valid,
    input  logic          ring_ready,
    output logic [AW-1:0] ring_addr,
    output logic          ring_excl,
    input  logic          rsp_valid,
    input  logic [AW-1:0] rsp_addr,
    output logic          rsp_err
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0]         slot_valid;
    logic [DEPTH-1:0]         slot_issued;
    logic [DEPTH-1:0]         slot_excl;
    logic [DEPTH-1:0][AW-1:0] slot_addr;
    logic [DEPTH-1:0]         hit_vec;
    logic                     rsp_hit;
    logic                     any_free;
    logic [IW-1:0]            alloc_idx;
    logic [IW-1:0]            head_idx;
    logic [CW-1:0]            fifo_cnt;
    logic                     covered;

    logic                     blk_pend;
    logic [AW-1:0]            pend_addr;
    logic                     pend_excl;
    logic                     stall_q;
    logic                     err_q;

    logic          acc, hit_any, hit_issued, merge, upg_en, new_ok, park, pend_go;
    logic          alloc_en, alloc_excl, pop;
    logic [AW-1:0] alloc_addr;
    logic [IW-1:0] hit_idx;

    pfq_filter u_filter (
        .held_state (lk_state),
        .want_excl  (req_excl),
        .covered    (covered)
    );

    pfq_slots #(.DEPTH(DEPTH), .AW(AW), .IW(IW)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmp_addr    (req_addr),
        .rsp_valid   (rsp_valid),
        .rsp_addr    (rsp_addr),
        .alloc_en    (alloc_en),
        .alloc_addr  (alloc_addr),
        .alloc_excl  (alloc_excl),
        .upg_en      (upg_en),
        .upg_idx     (hit_idx),
        .mark_en     (pop),
        .mark_idx    (head_idx),
        .slot_valid  (slot_valid),
        .slot_issued (slot_issued),
        .slot_excl   (slot_excl),
        .slot_addr   (slot_addr),
        .hit_vec     (hit_vec),
        .rsp_hit     (rsp_hit),
        .any_free    (any_free),
        .alloc_idx   (alloc_idx)
    );

    pfq_order #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_order (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_en),
        .push_idx (alloc_idx),
        .pop      (pop),
        .head_idx (head_idx),
        .nonempty (ring_valid),
        .count    (fifo_cnt)
    );

    // Encode the matching slot index
    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                hit_idx = IW'(i);
            end
        end
    end

    // Request disposition: filter, merge, allocate, park or drop
    always_comb begin
        pop        = ring_valid && ring_ready;
        acc        = req_valid && !blk_pend;
        hit_any    = |hit_vec;
        hit_issued = |(hit_vec & slot_issued) || (pop && hit_vec[head_idx]);
        merge      = acc && !covered && hit_any;
        upg_en     = merge && req_excl && !hit_issued;
        new_ok     = acc && !covered && !hit_any && any_free;
        park       = acc && !covered && !hit_any && !any_free && req_block;
        pend_go    = blk_pend && any_free;
        alloc_en   = new_ok || pend_go;
        alloc_addr = blk_pend ? pend_addr : req_addr;
        alloc_excl = blk_pend ? pend_excl : req_excl;
    end

    // Parked blocking request and stall hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_pend  <= 1'b0;
            pend_addr <= '0;
            pend_excl <= 1'b0;
            stall_q   <= 1'b0;
        end else begin
            if (park) begin
                blk_pend  <= 1'b1;
                pend_addr <= req_addr;
                pend_excl <= req_excl;
            end else if (pend_go) begin
                blk_pend <= 1'b0;
            end
            if (!blk_pend || pend_go) begin
                stall_q <= 1'b0;
            end else if (cpu_access) begin
                stall_q <= 1'b1;
            end
        end
    end

    // Sticky flag for responses that match nothing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (rsp_valid && !rsp_hit) begin
            err_q <= 1'b1;
        end
    end

    // Output drive
    always_comb begin
        lk_addr   = req_addr;
        stall     = blk_pend && !any_free && (cpu_access || stall_q);
        ring_addr = slot_addr[head_idx];
        ring_excl = slot_excl[head_idx];
        rsp_err   = err_q;
    end
endmodule

// File: rtl/pfq_checker.sv
// Module: cycle-level invariants of the prefetch queue, bound to the top.
// Assumes it sees the top's internal slot and order state.
module pfq_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 25,
    parameter int IW    = 2,
    parameter int CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_excl,
    input logic [1:0]       lk_state,
    input logic             blk_pend,
    input logic             rsp_valid,
    input logic [DEPTH-1:0] slot_valid,
    input logic [DEPTH-1:0] slot_issued,
    input logic [IW-1:0]    head_idx,
    input logic [CW-1:0]    fifo_cnt,
    input logic             ring_valid,
    input logic             ring_ready,
    input logic [AW-1:0]    ring_addr,
    input logic             stall,
    input logic             rsp_err
);
    logic req_cov;

    // Independent view of whether the cache covers the request
    always_comb begin
        req_cov = req_excl ? (lk_state >= 2'd2) : (lk_state != 2'd0);
    end

    AST_ORDER_WITHIN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        32'(fifo_cnt) <= $countones(slot_valid)); // R12
    AST_STALL_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (&slot_valid)); // R10
    AST_HEAD_NOT_ISSUED: assert property (@(posedge clk) disable iff (!rst_n)
        ring_valid |-> (slot_valid[head_idx] && !slot_issued[head_idx])); // R4
    AST_FILTER_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !blk_pend && req_cov && !rsp_valid) |=> $stable(slot_valid)); // R1
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> rsp_err); // R7
    AST_RING_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ring_valid && !ring_ready) |=> (ring_valid && $stable(ring_addr))); // R2
endmodule

bind pf_outstanding_queue pfq_checker #(
    .DEPTH(DEPTH), .AW(AW), .IW(IW), .CW(CW)
) u_pfq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_excl    (req_excl),
    .lk_state    (lk_state),
    .blk_pend    (blk_pend),
    .rsp_valid   (rsp_valid),
    .slot_valid  (slot_valid),
    .slot_issued (slot_issued),
    .head_idx    (head_idx),
    .fifo_cnt    (fifo_cnt),
    .ring_valid  (ring_valid),
    .ring_ready  (ring_ready),
    .ring_addr   (ring_addr),
    .stall       (stall),
    .rsp_err     (rsp_err)
);

// File: tb/test_pf_outstanding_queue.sv
// Bench: directed sweeps over a 4-entry, 8-bit-address queue.
module test_pf_outstanding_queue;
    localparam int DEPTH = 4;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_excl = 1'b0;
    logic          req_block = 1'b0;
    logic [AW-1:0] lk_addr;
    logic [1:0]    lk_state = 2'd0;
    logic          cpu_access = 1'b0;
    logic          stall;
    logic          ring_valid;
    logic          ring_ready = 1'b0;
    logic [AW-1:0] ring_addr;
    logic          ring_excl;
    logic          rsp_valid = 1'b0;
    logic [AW-1:0] rsp_addr = '0;
    logic          rsp_err;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    pf_outstanding_queue #(.DEPTH(DEPTH), .AW(AW)) i_pf_outstanding_queue (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_excl(req_excl), .req_block(req_block), .lk_addr(lk_addr),
        .lk_state(lk_state), .cpu_access(cpu_access), .stall(stall),
        .ring_valid(ring_valid), .ring_ready(ring_ready), .ring_addr(ring_addr),
        .ring_excl(ring_excl), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
        .rsp_err(rsp_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic send(input logic [7:0] a, input logic e, input logic b, input logic [1:0] st);
        req_valid = 1'b1; req_addr = a; req_excl = e; req_block = b; lk_state = st;
        @(negedge clk);
        req_valid = 1'b0; lk_state = 2'd0; req_block = 1'b0;
    endtask

    task automatic pop_one();
        ring_ready = 1'b1;
        @(negedge clk);
        ring_ready = 1'b0;
    endtask

    task automatic respond(input logic [7:0] a);
        rsp_valid = 1'b1; rsp_addr = a;
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 ring_valid", ring_valid, 0);
        chk("R11 stall", stall, 0);
        chk("R11 rsp_err", rsp_err, 0);

        // R1/R2 filter sweep over request kind and cache state
        for (int e = 0; e < 2; e++) begin
            for (int st = 0; st < 3; st++) begin
                logic [7:0] a;
                logic       exp_acc;
                a = 8'h10 + 8'(e * 4 + st);
                exp_acc = (e == 1) ? (st != 2) : (st == 0);
                send(a, e[0], 1'b0, st[1:0]);
                chk("R1 accept vs filter", ring_valid, exp_acc);
                chk("R2 lookup address", lk_addr, 0 + req_addr);
                if (exp_acc) begin
                    chk("R2 ring_addr", ring_addr, a);
                    chk("R2 ring_excl", ring_excl, e[0]);
                    @(negedge clk);
                    chk("R2 held while not ready", {ring_valid, ring_addr}, {1'b1, a});
                    pop_one();
                    chk("R2 single issue", ring_valid, 0);
                    respond(a);
                end
            end
        end

        // R3 arrival order, one per cycle
        for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), i[0], 1'b0, 2'd0);
        ring_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R3 order valid", ring_valid, 1);
            chk("R3 order addr", ring_addr, 8'h40 + 8'(i));
            chk("R3 order excl", ring_excl, i[0]);
            @(negedge clk);
        end
        ring_ready = 1'b0;
        chk("R3 drained", ring_valid, 0);

        // R8 non-blocking drop when full, R10 no stall
        cpu_access = 1'b1;
        send(8'h50, 1'b0, 1'b0, 2'd0);
        chk("R10 no stall on non-blocking", stall, 0);
        cpu_access = 1'b0;
        chk("R8 dropped, no ring", ring_valid, 0);
        respond(8'h42);
        chk("R8 dropped stays dropped", ring_valid, 0);
        chk("R6 out-of-order retire no error", rsp_err, 0);
        send(8'h51, 1'b0, 1'b0, 2'd0);
        chk("R6 freed slot reused", {ring_valid, ring_addr}, {1'b1, 8'h51});
        pop_one();

        // R9 blocking request parks and stalls
        send(8'h60, 1'b0, 1'b1, 2'd0);
        chk("R9 no stall before access", stall, 0);
        chk("R9 parked not issued", ring_valid, 0);
        cpu_access = 1'b1;
        #1 chk("R9 stall on access", stall, 1);
        @(negedge clk);
        cpu_access = 1'b0;
        req_valid = 1'b1; req_addr = 8'h61; req_excl = 1'b0; req_block = 1'b0;
        #1 chk("R9 stall held", stall, 1);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_valid = 1'b1; rsp_addr = 8'h40;
        #1 chk("R10 stall drops when slot frees", stall, 0);
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R9 parked request issued", {ring_valid, ring_addr}, {1'b1, 8'h60});
        chk("R10 stall low after", stall, 0);
        pop_one();
        chk("R9 request during park ignored", ring_valid, 0);

        // R6 retire in scrambled order
        respond(8'h51); respond(8'h41); respond(8'h60); respond(8'h43);
        chk("R6 all retired cleanly", rsp_err, 0);

        // R12 capacity: DEPTH accepted, next one dropped
        for (int i = 0; i < 5; i++) send(8'h70 + 8'(i), 1'b0, 1'b0, 2'd0);
        ring_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            chk("R12 capacity entry", {ring_valid, ring_addr}, {1'b1, 8'h70 + 8'(i)});
            @(negedge clk);
        end
        ring_ready = 1'b0;
        chk("R12 extra request absent", ring_valid, 0);
        for (int i = 0; i < 4; i++) respond(8'h70 + 8'(i));

        // R4 merge with upgrade, and plain merge
        send(8'h80, 1'b0, 1'b0, 2'd0);
        send(8'h80, 1'b1, 1'b0, 2'd0);
        chk("R4 upgraded to exclusive", {ring_valid, ring_excl}, {1'b1, 1'b1});
        pop_one();
        chk("R4 no duplicate", ring_valid, 0);
        respond(8'h80);
        send(8'h81, 1'b0, 1'b0, 2'd0);
        send(8'h81, 1'b0, 1'b0, 2'd0);
        pop_one();
        chk("R4 shared merge no duplicate", ring_valid, 0);
        respond(8'h81);

        // R5 exclusive after shared issued is discarded
        send(8'h82, 1'b0, 1'b0, 2'd0);
        pop_one();
        send(8'h82, 1'b1, 1'b0, 2'd0);
        chk("R5 discarded", ring_valid, 0);
        respond(8'h82);
        chk("R5 entry retired cleanly", rsp_err, 0);

        // R7 unmatched response
        respond(8'hEE);
        chk("R7 error set", rsp_err, 1);
        send(8'h83, 1'b0, 1'b0, 2'd0);
        chk("R7 queue unaffected", {ring_valid, ring_addr}, {1'b1, 8'h83});
        pop_one();
        respond(8'h83);
        chk("R7 error sticky", rsp_err, 1);

        finish_run();
    end
endmodule